// File: doc/BRIEF.md
# Byte-Packing Single-Channel DMA Engine

This block is one DMA channel that moves data between word-wide DRAM and a peripheral on a fixed chip-select bank of the system bus. Software loads a DRAM byte address, a peripheral bank address and a word count through a small 16-bit register port. It then writes a control word that sets the start bit and selects the direction and the data size. The engine then runs request/acknowledge cycles on its DRAM port and its peripheral port until the count is used up. It drops busy and raises a one-cycle done pulse.

When the peripheral is byte-wide, the engine packs two received bytes into one DRAM word before writing it. When sending, it reads one DRAM word and delivers it as two byte writes. Packing is big endian: the first peripheral byte is the upper half of the word. The DRAM address advances by one word after every DRAM access. The peripheral address never moves during a transfer.

Top module: `pkdma_engine`

## Requirements
- R1: After reset, busy, done, dram_req and per_req are 0, and every register reads 0.
- R2: Register indices on reg_addr are: 0 control/status, 1 word count, 2 DRAM address upper part, 3 DRAM address bits 15:0, 4 peripheral address upper part, 5 peripheral address bits 15:0. Each upper register holds address bits 27:16 in its bits 11:0 and reads 0 above them. The control write bits are: bit 0 start, bit 1 direction (1 = DRAM to peripheral, 0 = peripheral to DRAM), bit 2 size (1 = byte, 0 = word). A control read returns busy in bit 15 and the latched direction and size in bits 1 and 2.
- R3: A start write with a non-zero count sets busy at the next clock. The count register drops by one per word moved. At the clock that completes the last word, busy clears and done is high for exactly one cycle.
- R4: A start write while the count is zero raises done at the next clock for one cycle, leaves busy at 0 and issues no DRAM or peripheral request.
- R5: The DRAM address steps by 2 (one 16-bit word) after every acknowledged DRAM access. The n-th DRAM access of a transfer uses base + 2n, and the register reads back base + 2N after N words.
- R6: per_addr always carries bits 25:1 of the peripheral address register and never changes during a transfer.
- R7: In byte receive mode, each DRAM write is preceded by two peripheral reads. The first byte, taken from per_rdata[7:0], goes to dram_wdata[15:8] and the second to [7:0]. per_rdata[15:8] is ignored.
- R8: In byte send mode, each word is read once from DRAM and then written as two peripheral byte transfers. The first carries word bits 15:8 on per_wdata[7:0], the second bits 7:0, and per_wdata[15:8] is 0.
- R9: In word mode, each DRAM access pairs with exactly one peripheral access carrying all 16 bits unchanged.
- R10: While busy, writes to the address registers, the count register and the control register (including a new start) have no effect.
- R11: A request stays asserted until it is acknowledged. dram_we and per_we mark the write direction of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dram_req | output | 1 | DRAM access request |
| dram_we | output | 1 | DRAM request is a write |
| dram_addr | output | 28 | DRAM byte address |
| dram_wdata | output | 16 | DRAM write data |
| dram_rdata | input | 16 | DRAM read data, valid with ack |
| dram_ack | input | 1 | DRAM acknowledge |
| per_req | output | 1 | Peripheral access request |
| per_we | output | 1 | Peripheral request is a write |
| per_addr | output | 25 | Peripheral word address (bits 25:1) |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data, valid with ack |
| per_ack | input | 1 | Peripheral acknowledge |

## Verification
Busy rises one clock after the start write. Done and the zero-count completion appear one clock after the start write or after the final acknowledge. Each request is visible in the cycle after the previous acknowledge. The bench drives register writes and acknowledges at falling edges and samples at the next falling edge, which lies after exactly one rising edge. Data and address are checked at the falling edge where the acknowledge is raised, while the request is held stable. The register readback of address and count is taken only after done, when no further update is due.

// File: rtl/pkdma_pkg.sv
package pkdma_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_PGET,
      S_DPUT,
      S_DGET,
      S_PPUT
   } pk_state_t;

   localparam logic [2:0] RI_CTRL    = 3'd0;
   localparam logic [2:0] RI_COUNT   = 3'd1;
   localparam logic [2:0] RI_DRAM_HI = 3'd2;
   localparam logic [2:0] RI_DRAM_LO = 3'd3;
   localparam logic [2:0] RI_PER_HI  = 3'd4;
   localparam logic [2:0] RI_PER_LO  = 3'd5;

   localparam int CB_GO   = 0;
   localparam int CB_SEND = 1;
   localparam int CB_BYTE = 2;
   localparam int CB_BUSY = 15;
endpackage

// File: rtl/pkdma_regs.sv
module pkdma_regs
   import pkdma_pkg::*;
#(
   parameter int ADDR_W = 28,
   parameter int CNT_W  = 16,
   parameter int STEP   = 2,
   parameter int PER_HI = 25,
   parameter int PER_LO = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [2:0]               idx,
   input  logic [15:0]              wdata,
   output logic [15:0]              rdata,
   input  logic                     busy_i,
   input  logic                     send_i,
   input  logic                     byte_i,
   input  logic                     adv_i,
   input  logic                     dec_i,
   output logic [ADDR_W-1:0]        dram_addr_o,
   output logic [PER_HI-PER_LO:0]   per_addr_o,
   output logic [CNT_W-1:0]         cnt_o,
   output logic                     go_o,
   output logic                     go_send_o,
   output logic                     go_byte_o
);
   localparam int HI_W = ADDR_W - 16;

   logic [ADDR_W-1:0] dram_q;
   logic [ADDR_W-1:0] cs_q;
   logic [CNT_W-1:0]  cnt_q;

   assign go_o        = we && (idx == RI_CTRL) && wdata[CB_GO] && !busy_i;
   assign go_send_o   = wdata[CB_SEND];
   assign go_byte_o   = wdata[CB_BYTE];
   assign dram_addr_o = dram_q;
   assign per_addr_o  = cs_q[PER_HI:PER_LO];
   assign cnt_o       = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dram_q <= '0;
         cs_q   <= '0;
         cnt_q  <= '0;
      end else begin
         if (we && !busy_i) begin
            case (idx)
               RI_COUNT:   cnt_q                <= wdata[CNT_W-1:0];
               RI_DRAM_HI: dram_q[ADDR_W-1:16]  <= wdata[HI_W-1:0];
               RI_DRAM_LO: dram_q[15:0]         <= wdata;
               RI_PER_HI:  cs_q[ADDR_W-1:16]    <= wdata[HI_W-1:0];
               RI_PER_LO:  cs_q[15:0]           <= wdata;
               default: ;
            endcase
         end
         if (adv_i) dram_q <= dram_q + ADDR_W'(STEP);
         if (dec_i) cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   always_comb begin
      rdata = '0;
      case (idx)
         RI_CTRL: begin
            rdata[CB_BUSY] = busy_i;
            rdata[CB_SEND] = send_i;
            rdata[CB_BYTE] = byte_i;
         end
         RI_COUNT:   rdata[CNT_W-1:0] = cnt_q;
         RI_DRAM_HI: rdata[HI_W-1:0]  = dram_q[ADDR_W-1:16];
         RI_DRAM_LO: rdata            = dram_q[15:0];
         RI_PER_HI:  rdata[HI_W-1:0]  = cs_q[ADDR_W-1:16];
         RI_PER_LO:  rdata            = cs_q[15:0];
         default:    rdata            = '0;
      endcase
   end

   // R10: software writes cannot move the DRAM address during a transfer
   a_r10_dram_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && !adv_i |=> $stable(dram_q));
   // R10: count only moves by the sequencer while busy
   a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && !dec_i |=> $stable(cnt_q));
   // R6: peripheral bank address never moves during a transfer
   a_r6_cs_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(cs_q));
   // R5: one word step per acknowledged DRAM access
   a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> dram_q == $past(dram_q) + ADDR_W'(STEP));
endmodule

// File: rtl/pkdma_seq.sv
module pkdma_seq
   import pkdma_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             go_send_i,
   input  logic             go_byte_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dram_ack_i,
   input  logic             per_ack_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             send_o,
   output logic             byte_o,
   output logic             lane_o,
   output logic             dram_req_o,
   output logic             dram_we_o,
   output logic             per_req_o,
   output logic             per_we_o,
   output logic             adv_o,
   output logic             dec_o,
   output logic             pcap_o,
   output logic             dcap_o
);
   pk_state_t st_q;
   logic      send_q, byte_q, lane_q, done_q;
   logic      dram_fire, per_fire, word_end, last;

   assign dram_req_o = (st_q == S_DPUT) || (st_q == S_DGET);
   assign dram_we_o  = (st_q == S_DPUT);
   assign per_req_o  = (st_q == S_PGET) || (st_q == S_PPUT);
   assign per_we_o   = (st_q == S_PPUT);

   assign dram_fire = dram_req_o && dram_ack_i;
   assign per_fire  = per_req_o && per_ack_i;
   assign word_end  = !byte_q || lane_q;

   assign adv_o  = dram_fire;
   assign dec_o  = ((st_q == S_DPUT) && dram_fire) ||
                   ((st_q == S_PPUT) && per_fire && word_end);
   assign last   = dec_o && (cnt_i == CNT_W'(1));
   assign pcap_o = (st_q == S_PGET) && per_fire;
   assign dcap_o = (st_q == S_DGET) && dram_fire;

   assign busy_o = (st_q != S_IDLE);
   assign done_o = done_q;
   assign send_o = send_q;
   assign byte_o = byte_q;
   assign lane_o = lane_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         send_q <= 1'b0;
         byte_q <= 1'b0;
         lane_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: if (go_i) begin
               send_q <= go_send_i;
               byte_q <= go_byte_i;
               lane_q <= 1'b0;
               if (cnt_i == '0) done_q <= 1'b1;
               else             st_q   <= go_send_i ? S_DGET : S_PGET;
            end
            S_PGET: if (per_fire) begin
               lane_q <= !word_end;
               if (word_end) st_q <= S_DPUT;
            end
            S_DPUT: if (dram_fire) begin
               if (last) begin
                  st_q   <= S_IDLE;
                  done_q <= 1'b1;
               end else begin
                  st_q <= S_PGET;
               end
            end
            S_DGET: if (dram_fire) begin
               lane_q <= 1'b0;
               st_q   <= S_PPUT;
            end
            S_PPUT: if (per_fire) begin
               lane_q <= !word_end;
               if (last) begin
                  st_q   <= S_IDLE;
                  done_q <= 1'b1;
               end else if (word_end) begin
                  st_q <= S_DGET;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // R3: a non-zero start makes the channel busy
   a_r3_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
      go_i && (cnt_i != '0) |=> busy_o);
   // R3: every end of busy carries a done pulse
   a_r3_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R4: zero-count start finishes without a transfer
   a_r4_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
      go_i && (cnt_i == '0) |=> done_o && !busy_o && !dram_req_o && !per_req_o);
   // R11: requests are held until acknowledged
   a_r11_dram_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dram_req_o && !dram_ack_i |=> dram_req_o && $stable(dram_we_o));
   a_r11_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
      per_req_o && !per_ack_i |=> per_req_o && $stable(per_we_o));
endmodule

// File: rtl/pkdma_pack.sv
module pkdma_pack #(
   parameter int DATA_W     = 16,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pcap_i,
   input  logic              dcap_i,
   input  logic              byte_i,
   input  logic              lane_i,
   input  logic [DATA_W-1:0] per_rdata_i,
   input  logic [DATA_W-1:0] dram_rdata_i,
   output logic [DATA_W-1:0] dram_wdata_o,
   output logic [DATA_W-1:0] per_wdata_o
);
   localparam int BW = DATA_W / 2;

   logic [DATA_W-1:0] hold_q;
   logic              put_hi;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign put_hi = !lane_i;
         // R7: the second byte leaves the first (upper) byte untouched
         a_r7_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
            pcap_i && byte_i && lane_i |=> hold_q[DATA_W-1:BW] == $past(hold_q[DATA_W-1:BW]));
      end else begin : g_little
         assign put_hi = lane_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (dcap_i) begin
         hold_q <= dram_rdata_i;
      end else if (pcap_i) begin
         if (!byte_i)     hold_q              <= per_rdata_i;
         else if (put_hi) hold_q[DATA_W-1:BW] <= per_rdata_i[BW-1:0];
         else             hold_q[BW-1:0]      <= per_rdata_i[BW-1:0];
      end
   end

   assign dram_wdata_o = hold_q;
   assign per_wdata_o  = !byte_i ? hold_q :
                         {{BW{1'b0}}, (put_hi ? hold_q[DATA_W-1:BW] : hold_q[BW-1:0])};

   // R9: a word-mode DRAM read is forwarded unchanged
   a_r9_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
      dcap_i && !byte_i |=> per_wdata_o == $past(dram_rdata_i));
endmodule

// File: rtl/pkdma_engine.sv
module pkdma_engine #(
   parameter int ADDR_W     = 28,
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 16,
   parameter int PER_HI     = 25,
   parameter int PER_LO     = 1,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [2:0]              reg_addr,
   input  logic [15:0]             reg_wdata,
   output logic [15:0]             reg_rdata,
   output logic                    busy,
   output logic                    done,
   output logic                    dram_req,
   output logic                    dram_we,
   output logic [ADDR_W-1:0]       dram_addr,
   output logic [DATA_W-1:0]       dram_wdata,
   input  logic [DATA_W-1:0]       dram_rdata,
   input  logic                    dram_ack,
   output logic                    per_req,
   output logic                    per_we,
   output logic [PER_HI-PER_LO:0]  per_addr,
   output logic [DATA_W-1:0]       per_wdata,
   input  logic [DATA_W-1:0]       per_rdata,
   input  logic                    per_ack
);
   localparam int STEP = DATA_W / 8;

   generate
      if (DATA_W != 16) begin : g_bad_data
         $fatal(1, "DATA_W must equal the 16-bit register width");
      end
      if (ADDR_W <= 16 || ADDR_W > 32) begin : g_bad_addr
         $fatal(1, "ADDR_W must lie in 17..32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $fatal(1, "CNT_W must lie in 1..16");
      end
      if (PER_HI >= ADDR_W || PER_LO > PER_HI) begin : g_bad_per
         $fatal(1, "peripheral address slice out of range");
      end
   endgenerate

   logic             go, go_send, go_byte;
   logic             send_l, byte_l, lane;
   logic             adv, dec, pcap, dcap;
   logic [CNT_W-1:0] cnt;

   pkdma_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP), .PER_HI(PER_HI), .PER_LO(PER_LO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy_i(busy), .send_i(send_l), .byte_i(byte_l),
      .adv_i(adv), .dec_i(dec), .dram_addr_o(dram_addr), .per_addr_o(per_addr),
      .cnt_o(cnt), .go_o(go), .go_send_o(go_send), .go_byte_o(go_byte)
   );

   pkdma_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go), .go_send_i(go_send), .go_byte_i(go_byte),
      .cnt_i(cnt), .dram_ack_i(dram_ack), .per_ack_i(per_ack), .busy_o(busy),
      .done_o(done), .send_o(send_l), .byte_o(byte_l), .lane_o(lane),
      .dram_req_o(dram_req), .dram_we_o(dram_we), .per_req_o(per_req),
      .per_we_o(per_we), .adv_o(adv), .dec_o(dec), .pcap_o(pcap), .dcap_o(dcap)
   );

   pkdma_pack #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_pack (
      .clk(clk), .rst_n(rst_n), .pcap_i(pcap), .dcap_i(dcap), .byte_i(byte_l),
      .lane_i(lane), .per_rdata_i(per_rdata), .dram_rdata_i(dram_rdata),
      .dram_wdata_o(dram_wdata), .per_wdata_o(per_wdata)
   );
endmodule

// File: tb/pkdma_engine_test.sv
`timescale 1ns/1ps
module pkdma_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        busy, done;
   logic        dram_req, dram_we;
   logic [27:0] dram_addr;
   logic [15:0] dram_wdata;
   logic [15:0] dram_rdata = 16'd0;
   logic        dram_ack = 1'b0;
   logic        per_req, per_we;
   logic [24:0] per_addr;
   logic [15:0] per_wdata;
   logic [15:0] per_rdata = 16'd0;
   logic        per_ack = 1'b0;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   bit          x_send, x_byte;
   logic [27:0] x_dbase, x_cs;
   int          dacc, pacc;

   always #2.5 clk = ~clk;

   pkdma_engine uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
      .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .dram_ack(dram_ack),
      .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
      .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack)
   );

   function automatic logic [7:0] pbyte(int k);
      return 8'(k * 37 + 11);
   endfunction
   function automatic logic [15:0] pword(int k);
      return 16'(k * 4099 + 16'h1234);
   endfunction
   function automatic logic [15:0] rdpat(logic [27:0] a);
      return a[16:1] ^ 16'h5A3C;
   endfunction
   function automatic logic [15:0] rx_in(int k);
      return x_byte ? {8'hEE, pbyte(k)} : pword(k);
   endfunction
   function automatic logic [15:0] exp_rx(int w);
      return x_byte ? {pbyte(2 * w), pbyte(2 * w + 1)} : pword(w);
   endfunction
   function automatic logic [15:0] exp_tx(int k);
      logic [15:0] d;
      if (!x_byte) return rdpat(x_dbase + 28'(2 * k));
      d = rdpat(x_dbase + 28'(2 * (k / 2)));
      return (k % 2 == 0) ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk);
      reg_addr = idx; reg_wdata = val; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [15:0] val);
      @(negedge clk);
      reg_addr = idx;
      #1 val = reg_rdata;
   endtask

   // DRAM responder: R5, R7, R8, R9, R11
   initial begin
      forever begin
         @(negedge clk);
         if (dram_req === 1'b1) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            chk(!per_req, "R11 one side", {31'd0, per_req}, 32'd0);
            chk(dram_addr == x_dbase + 28'(2 * dacc), "R5 dram addr", {4'd0, dram_addr},
                {4'd0, x_dbase + 28'(2 * dacc)});
            chk(dram_we == !x_send, "R11 dram dir", {31'd0, dram_we}, {31'd0, !x_send});
            if (x_send) dram_rdata = rdpat(dram_addr);
            else chk(dram_wdata == exp_rx(dacc), x_byte ? "R7 packed word" : "R9 word",
                     {16'd0, dram_wdata}, {16'd0, exp_rx(dacc)});
            dram_ack = 1'b1;
            dacc++;
            @(negedge clk);
            dram_ack = 1'b0;
         end
      end
   end

   // peripheral responder: R6, R8, R9, R11
   initial begin
      forever begin
         @(negedge clk);
         if (per_req === 1'b1) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            chk(per_addr == x_cs[25:1], "R6 per addr", {7'd0, per_addr}, {7'd0, x_cs[25:1]});
            chk(per_we == x_send, "R11 per dir", {31'd0, per_we}, {31'd0, x_send});
            if (x_send) chk(per_wdata == exp_tx(pacc), x_byte ? "R8 byte out" : "R9 word out",
                            {16'd0, per_wdata}, {16'd0, exp_tx(pacc)});
            else per_rdata = rx_in(pacc);
            per_ack = 1'b1;
            pacc++;
            @(negedge clk);
            per_ack = 1'b0;
         end
      end
   end

   task automatic run_xfer(input bit send, input bit byt, input logic [27:0] dbase,
                           input logic [27:0] cs, input int n, input bit meddle);
      logic [15:0] h, l;
      int          t;
      x_send = send; x_byte = byt; x_dbase = dbase; x_cs = cs;
      dacc = 0; pacc = 0;
      wr(3'd2, {4'd0, dbase[27:16]});
      wr(3'd3, dbase[15:0]);
      wr(3'd4, {4'd0, cs[27:16]});
      wr(3'd5, cs[15:0]);
      wr(3'd1, 16'(n));
      wr(3'd0, {13'd0, byt, send, 1'b1});
      chk(busy == 1'b1, "R3 busy after start", {31'd0, busy}, 32'd1);
      if (meddle) begin
         wr(3'd3, 16'hBEEE);
         wr(3'd5, 16'h0F0E);
         wr(3'd1, 16'd40);
         wr(3'd0, {13'd0, !byt, !send, 1'b1});
         rd(3'd0, h);
         chk(h[2:1] == {byt, send}, "R10 mode kept", {30'd0, h[2:1]}, {30'd0, byt, send});
      end
      t = 0;
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(done == 1'b1, "R3 done pulse", {31'd0, done}, 32'd1);
      chk(busy == 1'b0, "R3 busy clear", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk(done == 1'b0, "R3 done one cycle", {31'd0, done}, 32'd0);
      chk(dacc == n, "R5 dram access count", 32'(dacc), 32'(n));
      chk(pacc == (byt ? 2 * n : n), byt ? "R7 R8 byte access count" : "R9 access count",
          32'(pacc), 32'(byt ? 2 * n : n));
      rd(3'd2, h); rd(3'd3, l);
      chk({h[11:0], l} == dbase + 28'(2 * n), "R5 R10 final dram addr",
          {4'd0, h[11:0], l}, {4'd0, dbase + 28'(2 * n)});
      rd(3'd4, h); rd(3'd5, l);
      chk({h[11:0], l} == cs, "R6 R10 cs kept", {4'd0, h[11:0], l}, {4'd0, cs});
      rd(3'd1, l);
      chk(l == 16'd0, "R3 count at zero", {16'd0, l}, 32'd0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL R3 watchdog expired actual=%0d expected=<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !dram_req && !per_req, "R1 outputs idle",
          {28'd0, busy, done, dram_req, per_req}, 32'd0);
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         chk(v == 16'd0, "R1 register zero", {16'd0, v}, 32'd0);
      end
      // R2 upper address field width
      wr(3'd2, 16'hFFFF);
      rd(3'd2, v);
      chk(v == 16'h0FFF, "R2 upper field", {16'd0, v}, 32'h0FFF);
      // R4 zero count
      x_send = 1'b0; x_byte = 1'b0; dacc = 0; pacc = 0;
      wr(3'd1, 16'd0);
      wr(3'd0, 16'h0001);
      chk(done && !busy, "R4 immediate done", {30'd0, done, busy}, 32'd2);
      repeat (6) begin
         @(negedge clk);
         chk(!done && !busy && !dram_req && !per_req, "R4 no activity",
             {28'd0, done, busy, dram_req, per_req}, 32'd0);
      end
      // directed: each mode
      run_xfer(1'b0, 1'b0, 28'h0012340, 28'h2000006, 3, 1'b0);
      run_xfer(1'b0, 1'b1, 28'h0FFFFFC, 28'h0ABCDE2, 4, 1'b0);
      run_xfer(1'b1, 1'b0, 28'h1000000, 28'h3FFFFFE, 3, 1'b0);
      run_xfer(1'b1, 1'b1, 28'h0000010, 28'h1234566, 1, 1'b0);
      // R10 writes while busy
      run_xfer(1'b1, 1'b1, 28'h0456780, 28'h0010002, 5, 1'b1);
      run_xfer(1'b0, 1'b1, 28'h0777770, 28'h0020004, 5, 1'b1);
      // constrained random
      for (int k = 0; k < 14; k++) begin
         run_xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  28'($urandom) & 28'hFFFFFFE, 28'($urandom),
                  int'($urandom_range(1, 7)), 1'($urandom_range(0, 1)));
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule